// File: doc/BRIEF.md
# Reset Boot-Mode Sequencer

This block decides when a processor core may leave reset. The core stays stalled while the active-low reset is asserted. On the first clock after reset is released, the block latches a two-bit boot strap and an endianness strap. It then picks one of three ways to lift the stall.

- **No boot:** the stall drops on that first clock.
- **Host boot:** the stall holds until an external host rings a doorbell on the host port chosen by a separate strap.
- **ROM boot:** the block copies a fixed region of a byte-wide external ROM into local memory starting at address 0. It packs every four bytes into one 32-bit word write, and lifts the stall once the last word is written.

The doorbell is a single flag that the core must clear. A ring that arrives while the core is stalled only releases the boot; it never becomes a core interrupt. While the flag is set, further rings are ignored. In every mode the core begins fetching at address 0. The ROM read port uses a request/valid handshake with any latency, and only one read is outstanding at a time.

Top module: `boot_release_seq`

## Requirements
- R1: While rst_n is low, core_stall is 1 and mem_we, rom_req, boot_done, doorbell_flag and core_irq are 0, even when reset lands in the middle of a ROM copy.
- R2: The strap encodings are 2'b01 = host boot, 2'b10 = ROM boot, 2'b00 and 2'b11 = no boot. The boot-mode and endianness straps are sampled on the first rising clock after rst_n goes high, and later changes to them have no effect until the next reset.
- R3: In no-boot mode, core_stall is 0 after the first rising clock following reset release, and no ROM read or memory write occurs.
- R4: In host boot, core_stall stays 1 until an accepted doorbell on the selected host port. In the other modes, doorbells do not change core_stall. Once core_stall is 0 it stays 0 until reset.
- R5: With host_port_strap = 0 only host0_doorbell counts, and with host_port_strap = 1 only host1_doorbell counts. A ring on the other port neither sets doorbell_flag nor releases the stall.
- R6: A doorbell accepted while the core is stalled sets doorbell_flag and raises no core_irq.
- R7: doorbell_flag stays 1 until core_doorbell_clr. Rings while it is 1 are ignored and raise no core_irq. After a clear, a ring while the core runs sets doorbell_flag and pulses core_irq for one cycle, starting the clock after the ring.
- R8: ROM boot issues ROM_BYTES single-outstanding reads at byte addresses ROM_BASE+0, +1, … in ascending order. It makes ROM_BYTES/4 writes to local byte addresses 0, 4, 8, … in ascending order.
- R9: With the endianness strap at 0, the first byte of each group of four lands in bits [7:0]. With the strap at 1, it lands in bits [31:24]. Later bytes follow in the same direction.
- R10: Each word write is issued only after all four of its bytes have returned. A rom_valid with no read outstanding is ignored. core_stall falls on the clock after the last word write.
- R11: boot_done is high for exactly one cycle per boot, in the first cycle in which core_stall is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_mode_strap | input | 2 | Boot mode strap |
| big_endian_strap | input | 1 | Byte-packing order strap (1 = first byte in bits [31:24]) |
| host_port_strap | input | 1 | Selects which host port may ring the doorbell |
| host0_doorbell | input | 1 | Doorbell write strobe from host port 0 |
| host1_doorbell | input | 1 | Doorbell write strobe from host port 1 |
| core_doorbell_clr | input | 1 | Core strobe that clears the doorbell flag |
| rom_req | output | 1 | One-cycle ROM byte read request |
| rom_addr | output | ROM_AW | ROM byte address, held while a read is outstanding |
| rom_valid | input | 1 | ROM read data valid |
| rom_data | input | 8 | ROM read data byte |
| mem_we | output | 1 | Local memory word write strobe |
| mem_addr | output | MEM_AW | Local memory byte address of the write |
| mem_wdata | output | 32 | Local memory write data |
| core_stall | output | 1 | Holds the core stalled while 1; the core fetches from address 0 once it drops |
| boot_done | output | 1 | One-cycle pulse when the stall is lifted |
| doorbell_flag | output | 1 | Current state of the doorbell bit |
| core_irq | output | 1 | One-cycle doorbell interrupt to a running core |

## Verification
The bench builds the block with ROM_BYTES = 32 and ROM_BASE = 32'h0040_0000. The copy is eight words, so a full ROM boot, including the last-word write and the release on the following clock, completes in a few hundred cycles. The ROM model rotates its read latency over one to three cycles. After every real byte it also drives a stray valid carrying garbage data. Each boot mode, both host ports and both byte orders appear in the walked table, and a directed test resets the block in the middle of a copy.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [1:0] {
    BK_NONE = 2'd0,
    BK_HOST = 2'd1,
    BK_ROM  = 2'd2
  } boot_kind_e;

  // 01 = host, 10 = ROM, anything else runs with no boot
  function automatic boot_kind_e decode_strap(input logic [1:0] s);
    boot_kind_e k;
    case (s)
      2'b01:   k = BK_HOST;
      2'b10:   k = BK_ROM;
      default: k = BK_NONE;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/boot_strap_latch.sv
module boot_strap_latch
  import boot_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_pins,
  input  logic       endian_pin,
  output logic       armed,
  output logic       first_cycle,
  output boot_kind_e kind_now,
  output boot_kind_e kind_q,
  output logic       big_endian_q
);

  logic armed_q;
  logic load_en;

  always_comb begin
    kind_now    = decode_strap(mode_pins);
    load_en     = !armed_q;
    first_cycle = !armed_q;
    armed       = armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q      <= 1'b0;
      kind_q       <= BK_NONE;
      big_endian_q <= 1'b0;
    end else if (load_en) begin
      armed_q      <= 1'b1;
      kind_q       <= kind_now;
      big_endian_q <= endian_pin;
    end
  end

endmodule

// File: rtl/doorbell_unit.sv
module doorbell_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic ring0,
  input  logic ring1,
  input  logic port_sel,
  input  logic clr,
  input  logic stalled,
  output logic flag,
  output logic accept,
  output logic irq
);

  logic flag_q, flag_d;
  logic irq_q, irq_d;
  logic ring_sel;

  always_comb begin
    ring_sel = port_sel ? ring1 : ring0;
    accept   = ring_sel && !flag_q && !clr;
    flag_d   = clr ? 1'b0 : (flag_q || accept);
    irq_d    = accept && !stalled;
    flag     = flag_q;
    irq      = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  // R7: only the core clear can drop the flag
  a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);

endmodule

// File: rtl/rom_byte_packer.sv
module rom_byte_packer #(
  parameter int ROM_BYTES = 1024,
  parameter int ROM_AW    = 32,
  parameter int MEM_AW    = 32,
  parameter logic [ROM_AW-1:0] ROM_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              big_endian,
  output logic              rom_req,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic              rom_valid,
  input  logic [7:0]        rom_data,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic              copy_done
);

  localparam int CW = $clog2(ROM_BYTES);
  localparam logic [CW-1:0] LAST_IDX = CW'(ROM_BYTES - 1);

  logic          busy_q, busy_d;
  logic          wait_q, wait_d;
  logic          req_q, req_d;
  logic          be_q, be_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [31:0]   sh_q, sh_d;
  logic          we_q, we_d;
  logic [31:0]   wdata_q, wdata_d;
  logic [CW-1:0] waddr_q, waddr_d;
  logic          done_q, done_d;
  logic [31:0]   packed_w;

  always_comb begin
    packed_w = be_q ? {sh_q[23:0], rom_data} : {rom_data, sh_q[31:8]};
    busy_d  = busy_q;
    wait_d  = wait_q;
    be_d    = be_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    wdata_d = wdata_q;
    waddr_d = waddr_q;
    req_d   = 1'b0;
    we_d    = 1'b0;
    done_d  = 1'b0;
    if (start) begin
      busy_d = 1'b1;
      wait_d = 1'b0;
      cnt_d  = '0;
      be_d   = big_endian;
    end else if (busy_q) begin
      if (!wait_q) begin
        req_d  = 1'b1;
        wait_d = 1'b1;
      end else if (rom_valid) begin
        sh_d   = packed_w;
        wait_d = 1'b0;
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q[1:0] == 2'b11) begin
          we_d    = 1'b1;
          wdata_d = packed_w;
          waddr_d = {cnt_q[CW-1:2], 2'b00};
        end
        if (cnt_q == LAST_IDX) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      wait_q  <= 1'b0;
      req_q   <= 1'b0;
      be_q    <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      waddr_q <= '0;
      done_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      wait_q  <= wait_d;
      req_q   <= req_d;
      be_q    <= be_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      we_q    <= we_d;
      wdata_q <= wdata_d;
      waddr_q <= waddr_d;
      done_q  <= done_d;
    end
  end

  always_comb begin
    rom_req   = req_q;
    rom_addr  = ROM_BASE + {{(ROM_AW-CW){1'b0}}, cnt_q};
    mem_we    = we_q;
    mem_addr  = {{(MEM_AW-CW){1'b0}}, waddr_q};
    mem_wdata = wdata_q;
    copy_done = done_q;
  end

  // R8: a request is never followed directly by another request
  a_r8_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    rom_req |=> !rom_req);

  // R10: a word write always follows a returned byte
  a_r10_write_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(rom_valid));

endmodule

// File: rtl/boot_release_seq.sv
module boot_release_seq
  import boot_seq_pkg::*;
#(
  parameter int ROM_BYTES = 1024,
  parameter int ROM_AW    = 32,
  parameter int MEM_AW    = 32,
  parameter logic [ROM_AW-1:0] ROM_BASE = 32'h9000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        boot_mode_strap,
  input  logic              big_endian_strap,
  input  logic              host_port_strap,
  input  logic              host0_doorbell,
  input  logic              host1_doorbell,
  input  logic              core_doorbell_clr,
  output logic              rom_req,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic              rom_valid,
  input  logic [7:0]        rom_data,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic              core_stall,
  output logic              boot_done,
  output logic              doorbell_flag,
  output logic              core_irq
);

  logic       armed, first_cycle, big_q;
  boot_kind_e kind_now, kind_q;
  logic       db_accept, copy_done, start_copy, release_ev;
  logic       stall_q, stall_d, done_q, done_d;

  boot_strap_latch u_straps (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_pins    (boot_mode_strap),
    .endian_pin   (big_endian_strap),
    .armed        (armed),
    .first_cycle  (first_cycle),
    .kind_now     (kind_now),
    .kind_q       (kind_q),
    .big_endian_q (big_q)
  );

  doorbell_unit u_bell (
    .clk      (clk),
    .rst_n    (rst_n),
    .ring0    (host0_doorbell),
    .ring1    (host1_doorbell),
    .port_sel (host_port_strap),
    .clr      (core_doorbell_clr),
    .stalled  (stall_q),
    .flag     (doorbell_flag),
    .accept   (db_accept),
    .irq      (core_irq)
  );

  rom_byte_packer #(
    .ROM_BYTES (ROM_BYTES),
    .ROM_AW    (ROM_AW),
    .MEM_AW    (MEM_AW),
    .ROM_BASE  (ROM_BASE)
  ) u_copy (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_copy),
    .big_endian (big_endian_strap),
    .rom_req    (rom_req),
    .rom_addr   (rom_addr),
    .rom_valid  (rom_valid),
    .rom_data   (rom_data),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .copy_done  (copy_done)
  );

  always_comb begin
    start_copy = first_cycle && (kind_now == BK_ROM);
    release_ev = (first_cycle && (kind_now == BK_NONE))
               || (armed && (kind_q == BK_HOST) && db_accept)
               || copy_done;
    stall_d = stall_q && !release_ev;
    done_d  = stall_q && release_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      stall_q <= stall_d;
      done_q  <= done_d;
    end
  end

  always_comb begin
    core_stall = stall_q;
    boot_done  = done_q;
  end

  logic unused_big;
  assign unused_big = big_q;

  // R4: once released the core keeps running until reset
  a_r4_stall_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !core_stall |=> !core_stall);

  // R11: the done pulse marks the first running cycle
  a_r11_done_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |-> (!core_stall && $past(core_stall)));

  // R6: no interrupt comes from a ring taken while stalled
  a_r6_no_irq_from_stall: assert property (@(posedge clk) disable iff (!rst_n)
    core_irq |-> !$past(core_stall));

endmodule

// File: tb/boot_release_seq_tb_top.sv
module boot_release_seq_tb_top;

  localparam int ROM_BYTES = 32;
  localparam int WORDS     = ROM_BYTES / 4;
  localparam logic [31:0] ROM_BASE = 32'h0040_0000;

  // table entry: {mode[1:0], host port, big endian}
  localparam logic [3:0] VEC [7] = '{
    4'b00_0_0, 4'b11_0_0, 4'b01_0_0, 4'b01_1_0,
    4'b10_0_0, 4'b10_0_1, 4'b10_1_1
  };

  logic        clk;
  logic        rst_n = 1'b0;
  logic [1:0]  boot_mode_strap = 2'b00;
  logic        big_endian_strap = 1'b0;
  logic        host_port_strap = 1'b0;
  logic        host0_doorbell = 1'b0;
  logic        host1_doorbell = 1'b0;
  logic        core_doorbell_clr = 1'b0;
  logic        rom_req;
  logic [31:0] rom_addr;
  logic        rom_valid = 1'b0;
  logic [7:0]  rom_data = 8'h00;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        core_stall, boot_done, doorbell_flag, core_irq;

  int checks = 0;
  int errors = 0;

  boot_release_seq #(
    .ROM_BYTES (ROM_BYTES),
    .ROM_AW    (32),
    .MEM_AW    (32),
    .ROM_BASE  (ROM_BASE)
  ) dut_i (
    .clk (clk), .rst_n (rst_n),
    .boot_mode_strap (boot_mode_strap), .big_endian_strap (big_endian_strap),
    .host_port_strap (host_port_strap),
    .host0_doorbell (host0_doorbell), .host1_doorbell (host1_doorbell),
    .core_doorbell_clr (core_doorbell_clr),
    .rom_req (rom_req), .rom_addr (rom_addr),
    .rom_valid (rom_valid), .rom_data (rom_data),
    .mem_we (mem_we), .mem_addr (mem_addr), .mem_wdata (mem_wdata),
    .core_stall (core_stall), .boot_done (boot_done),
    .doorbell_flag (doorbell_flag), .core_irq (core_irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] rom_byte(input int a);
    return 8'((a * 37 + 90) ^ (a >> 3));
  endfunction

  function automatic logic [31:0] exp_word(input int w, input bit be);
    logic [7:0] b0, b1, b2, b3;
    b0 = rom_byte(4*w);   b1 = rom_byte(4*w+1);
    b2 = rom_byte(4*w+2); b3 = rom_byte(4*w+3);
    return be ? {b0, b1, b2, b3} : {b3, b2, b1, b0};
  endfunction

  // ROM model: rotating latency, plus a stray valid after every real byte
  bit          pend = 0, spur = 0;
  int          lat_left = 0, rot = 0;
  logic [31:0] paddr = '0;
  always @(negedge clk) begin
    if (!rst_n) begin
      pend = 0; spur = 0; rom_valid = 1'b0;
    end else begin
      rom_valid = 1'b0;
      if (spur) begin
        rom_valid = 1'b1; rom_data = 8'hEE; spur = 0;
      end else if (pend) begin
        if (lat_left == 0) begin
          rom_valid = 1'b1; rom_data = rom_byte(int'(paddr - ROM_BASE));
          pend = 0; spur = 1;
        end else lat_left--;
      end
      if (rom_req) begin
        pend = 1; paddr = rom_addr; lat_left = rot; rot = (rot + 1) % 3;
      end
    end
  end

  // output monitor
  int   cyc = 0, n_done = 0, n_irq = 0, n_we = 0, n_req = 0;
  int   fall_cyc = -1, last_we_cyc = -1;
  bit   addr_bad = 0, order_bad = 0, we_running = 0;
  logic prev_stall = 1'b1;
  logic [31:0] got [WORDS];
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (boot_done) n_done++;
      if (core_irq) n_irq++;
      if (rom_req) begin
        if (rom_addr != ROM_BASE + 32'(n_req)) addr_bad = 1;
        n_req++;
      end
      if (mem_we) begin
        if (mem_addr != 32'(n_we * 4)) order_bad = 1;
        if (n_we < WORDS) got[n_we] = mem_wdata;
        if (!core_stall) we_running = 1;
        last_we_cyc = cyc;
        n_we++;
      end
      if (prev_stall && !core_stall) fall_cyc = cyc;
    end
    prev_stall = core_stall;
  end

  task automatic clear_mon();
    n_done = 0; n_irq = 0; n_we = 0; n_req = 0;
    fall_cyc = -1; last_we_cyc = -1;
    addr_bad = 0; order_bad = 0; we_running = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ring(input bit port);
    if (port) host1_doorbell = 1'b1; else host0_doorbell = 1'b1;
    tick();
    host0_doorbell = 1'b0; host1_doorbell = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic run_case(input logic [1:0] mode, input bit sel, input bit be);
    bit held;
    rst_n = 1'b0; boot_mode_strap = mode; host_port_strap = sel;
    big_endian_strap = be; core_doorbell_clr = 1'b0;
    repeat (3) tick();
    chk(core_stall == 1'b1, "R1 stall in reset", 32'(core_stall), 32'd1);
    chk({mem_we, rom_req, boot_done, doorbell_flag, core_irq} == 5'b0,
        "R1 outputs idle", 32'({mem_we, rom_req, boot_done, doorbell_flag, core_irq}), 32'd0);
    clear_mon();
    rst_n = 1'b1;
    tick();
    // R2: strap changes after the sampling clock must not matter
    boot_mode_strap = (mode == 2'b10) ? 2'b01 : 2'b10;
    big_endian_strap = ~be;
    if (mode == 2'b00 || mode == 2'b11) begin
      chk(core_stall == 1'b0, "R3 released at once", 32'(core_stall), 32'd0);
      chk(boot_done == 1'b1, "R11 done with release", 32'(boot_done), 32'd1);
      repeat (10) tick();
      chk(n_req == 0 && n_we == 0, "R3/R2 no ROM traffic", 32'(n_req + n_we), 32'd0);
      chk(n_done == 1, "R11 single pulse", 32'(n_done), 32'd1);
    end else if (mode == 2'b01) begin
      held = 1;
      repeat (8) begin tick(); if (!core_stall) held = 0; end
      chk(held, "R4 host holds stall", 32'(held), 32'd1);
      chk(n_req == 0, "R2 late strap ignored", 32'(n_req), 32'd0);
      ring(!sel);
      repeat (3) tick();
      chk(core_stall == 1'b1, "R5 other port no release", 32'(core_stall), 32'd1);
      chk(doorbell_flag == 1'b0, "R5 other port no flag", 32'(doorbell_flag), 32'd0);
      ring(sel);
      chk(core_stall == 1'b0, "R4 doorbell releases", 32'(core_stall), 32'd0);
      chk(doorbell_flag == 1'b1, "R6 flag set", 32'(doorbell_flag), 32'd1);
      chk(boot_done == 1'b1, "R11 done with release", 32'(boot_done), 32'd1);
      repeat (3) tick();
      chk(n_irq == 0, "R6 no irq from boot ring", 32'(n_irq), 32'd0);
      ring(sel);
      repeat (2) tick();
      chk(n_irq == 0 && doorbell_flag, "R7 ring ignored while set", 32'(n_irq), 32'd0);
      core_doorbell_clr = 1'b1;
      tick();
      core_doorbell_clr = 1'b0;
      chk(doorbell_flag == 1'b0, "R7 core clears flag", 32'(doorbell_flag), 32'd0);
      ring(sel);
      chk(core_irq == 1'b1, "R7 irq after clear", 32'(core_irq), 32'd1);
      tick();
      chk(n_irq == 1 && doorbell_flag, "R7 one irq pulse", 32'(n_irq), 32'd1);
      chk(n_done == 1, "R11 single pulse", 32'(n_done), 32'd1);
    end else begin
      ring(1'b0); ring(1'b1);
      chk(core_stall == 1'b1, "R4 ring ignored in ROM boot", 32'(core_stall), 32'd1);
      for (int i = 0; i < 5000 && core_stall; i++) tick();
      chk(core_stall == 1'b0, "R8 copy completes", 32'(core_stall), 32'd0);
      chk(n_req == ROM_BYTES, "R8 read count", 32'(n_req), 32'(ROM_BYTES));
      chk(n_we == WORDS, "R8 write count", 32'(n_we), 32'(WORDS));
      chk(!addr_bad && !order_bad, "R8 address order", 32'({addr_bad, order_bad}), 32'd0);
      for (int w = 0; w < WORDS; w++)
        chk(got[w] == exp_word(w, be), "R9 packed word", got[w], exp_word(w, be));
      chk(!we_running, "R10 writes before release", 32'(we_running), 32'd0);
      chk(fall_cyc == last_we_cyc + 1, "R10 release after last write",
          32'(fall_cyc - last_we_cyc), 32'd1);
      chk(n_done == 1, "R11 single pulse", 32'(n_done), 32'd1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R8: run hung, actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick();
    for (int v = 0; v < 7; v++)
      run_case(VEC[v][3:2], VEC[v][1], VEC[v][0]);
    // directed: reset in the middle of a ROM copy
    rst_n = 1'b0; boot_mode_strap = 2'b10;
    repeat (2) tick();
    rst_n = 1'b1;
    repeat (20) tick();
    rst_n = 1'b0;
    #1;
    chk(core_stall == 1'b1, "R1 mid-copy reset stalls", 32'(core_stall), 32'd1);
    chk(mem_we == 1'b0 && rom_req == 1'b0, "R1 mid-copy reset idles",
        32'({mem_we, rom_req}), 32'd0);
    finish_run();
  end

endmodule